// File: doc/BRIEF.md
# Multi-channel interrupt multiplexer

This block takes one shared group of level-sensitive interrupt request lines and fans them out to a set of independent output channels. Every channel sees every source. There is no fixed wiring from a source to a channel. Each channel keeps a private enable mask. The channel's single output line is high while any source that is enabled for it is pending.

Software uses the masks to choose how sources are grouped. It can enable every source on one channel to get a single combined request. It can also split the sources across channels, so that each output goes to a different processor, or so that the output that fires shows which group raised the request. A source may be enabled on any number of channels at once.

Sources are synchronised to the block clock before masking. A small register port gives access to each channel's mask, which can be read and written, and to its pending view, which is read-only. The port uses single-cycle read and write strobes. Read data comes back one cycle after the strobe.

Top module: `irqmux_top`

## Requirements
- R1: While reset is held and right after it, every channel mask is zero, every output line is low, `rd_valid` is low and `rd_data` is zero.
- R2: The channel selected by `addr` is `addr / 8`, and the register within it is `addr % 8`. A write strobe at register 0 replaces that channel's mask with `wdata`, where bit i enables source i. A read strobe at register 0 returns the mask.
- R3: A read of register 4 returns the channel's pending view: the synchronised source levels ANDed with that channel's mask. A write to register 4 changes no mask.
- R4: Output `irq[c]` is high exactly when the synchronised sources ANDed with channel c's mask are non-zero. The output is registered, so it reflects the mask and levels held before the previous rising edge.
- R5: A source change that is stable before rising edge k shows on the enabled outputs just after edge k+2. It passes two synchroniser flops and the output register.
- R6: A write that masks the last pending source of a channel takes effect at its edge, and the channel's output goes low on the following edge.
- R7: One source enabled on several channels drives all of those outputs together. A mask write to one channel leaves every other channel's mask unchanged.
- R8: Register offsets other than 0 and 4 read as zero, and writes to them change no mask.
- R9: `rd_valid` is high for exactly the one cycle after each read strobe. When `rd_valid` is low, `rd_data` is zero.
- R10: A read and a write to the same mask in one cycle return the mask value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | 32 | Level-sensitive interrupt sources, asynchronous |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 6 | Byte address: channel times 8 plus register offset |
| wdata | input | 32 | Write data |
| irq | output | 8 | One interrupt line per channel |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |

## Verification
Each result has its own latency. A read answers one rising edge after its strobe. A mask write changes the outputs one edge after the write edge. A source change reaches the outputs three edges after it is applied. The bench drives inputs on falling edges and compares every output on the next falling edge against a behavioural model. The model delays the sources through a two-entry queue and keeps the masks in integer arrays. The directed checks count falling edges to land on the exact cycle where each output is due: the cycle just before the change and the cycle it appears.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
  localparam int MASK_OFF   = 0;
  localparam int STATUS_OFF = 4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_STATUS = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irqmux_sync.sv
module irqmux_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/irqmux_chan.sv
module irqmux_chan #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] lvl_sync,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] pending,
  output logic               irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_wdata;
    end
  end

  assign pending = lvl_sync & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |pending;
    end
  end
endmodule

// File: rtl/irqmux_regif.sv
module irqmux_regif
  import irqmux_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_SRC   = 32,
  parameter int ADDR_W    = 6,
  parameter int CH_STRIDE = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_CH*NUM_SRC-1:0] mask_flat,
  input  logic [NUM_CH*NUM_SRC-1:0] pend_flat,
  output logic [NUM_CH-1:0]         mask_we,
  output logic                      rd_valid,
  output logic [NUM_SRC-1:0]        rd_data
);
  logic [ADDR_W-1:0]  ch_idx;
  logic [ADDR_W-1:0]  reg_off;
  logic               ch_ok;
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] rd_mux;

  assign ch_idx  = addr / ADDR_W'(CH_STRIDE);
  assign reg_off = addr % ADDR_W'(CH_STRIDE);
  assign ch_ok   = (ch_idx < ADDR_W'(NUM_CH));

  always_comb begin
    sel = SEL_NONE;
    if (ch_ok && reg_off == ADDR_W'(MASK_OFF))   sel = SEL_MASK;
    if (ch_ok && reg_off == ADDR_W'(STATUS_OFF)) sel = SEL_STATUS;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign mask_we[c] = wr_en && (sel == SEL_MASK) && (ch_idx == ADDR_W'(c));
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_MASK:   rd_mux = mask_flat[ch_idx*NUM_SRC +: NUM_SRC];
      SEL_STATUS: rd_mux = pend_flat[ch_idx*NUM_SRC +: NUM_SRC];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/irqmux_top.sv
module irqmux_top #(
  parameter int NUM_CH    = 8,
  parameter int NUM_SRC   = 32,
  parameter int CH_STRIDE = 8,
  parameter int ADDR_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_CH-1:0]  irq,
  output logic               rd_valid,
  output logic [NUM_SRC-1:0] rd_data
);
  localparam int FLAT_W = NUM_CH * NUM_SRC;

  logic [NUM_SRC-1:0] lvl_sync;
  logic [FLAT_W-1:0]  mask_flat;
  logic [FLAT_W-1:0]  pend_flat;
  logic [NUM_CH-1:0]  mask_we;

  irqmux_sync #(.W(NUM_SRC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (src),
    .sync_out (lvl_sync)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irqmux_chan #(.NUM_SRC(NUM_SRC)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_sync   (lvl_sync),
      .mask_we    (mask_we[c]),
      .mask_wdata (wdata),
      .mask_q     (mask_flat[c*NUM_SRC +: NUM_SRC]),
      .pending    (pend_flat[c*NUM_SRC +: NUM_SRC]),
      .irq_q      (irq[c])
    );
  end

  irqmux_regif #(
    .NUM_CH    (NUM_CH),
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .CH_STRIDE (CH_STRIDE)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .mask_flat (mask_flat),
    .pend_flat (pend_flat),
    .mask_we   (mask_we),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/irqmux_checks.sv
module irqmux_checks #(
  parameter int NUM_CH    = 8,
  parameter int NUM_SRC   = 32,
  parameter int CH_STRIDE = 8,
  parameter int ADDR_W    = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        src,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [NUM_CH-1:0]         irq,
  input logic                      rd_valid,
  input logic [NUM_SRC-1:0]        rd_data,
  input logic [NUM_CH*NUM_SRC-1:0] mask_flat
);
  logic [ADDR_W-1:0] off_chk;
  assign off_chk = addr % ADDR_W'(CH_STRIDE);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (irq == '0 && mask_flat == '0 && !rd_valid));

  p_status_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off_chk == ADDR_W'(4)) |=> $stable(mask_flat));

  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && rd_data == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5: a rising output traces back to an enabled source three edges earlier
    p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |->
        (($past(src, 3) & $past(mask_flat[c*NUM_SRC +: NUM_SRC], 1)) != '0));
    // R6: a falling output means nothing enabled was pending
    p_fall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[c]) |->
        (($past(src, 3) & $past(mask_flat[c*NUM_SRC +: NUM_SRC], 1)) == '0));
    // R4: a channel with an empty mask keeps its output low
    p_empty_mask_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_flat[c*NUM_SRC +: NUM_SRC] == '0) |=> !irq[c]);
  end
endmodule

bind irqmux_top irqmux_checks #(
  .NUM_CH    (NUM_CH),
  .NUM_SRC   (NUM_SRC),
  .CH_STRIDE (CH_STRIDE),
  .ADDR_W    (ADDR_W)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .src       (src),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .irq       (irq),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .mask_flat (mask_flat)
);

// File: tb/irqmux_top_bench.sv
module irqmux_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  irq;
  logic        rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit armed = 1'b0;

  always #2.5 clk = ~clk;

  irqmux_top u_irqmux_top (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .irq(irq), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // behavioural reference model
  logic [31:0] m_mask [8];
  logic [31:0] hist [$];
  logic [7:0]  m_irq;
  logic        m_rdv;
  logic [31:0] m_rdd;

  function automatic logic [31:0] model_read(input int a, input logic [31:0] lvl);
    int ch = a / 8;
    int off = a % 8;
    if (ch >= 8) return '0;
    if (off == 0) return m_mask[ch];
    if (off == 4) return lvl & m_mask[ch];
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_mask[i] = '0;
      hist.delete();
      hist.push_back('0);
      hist.push_back('0);
      m_irq = '0;
      m_rdv = 1'b0;
      m_rdd = '0;
      armed = 1'b1;
    end else begin
      logic [31:0] lvl;
      lvl = hist[0];
      for (int i = 0; i < 8; i++) m_irq[i] = ((lvl & m_mask[i]) != 0);
      m_rdv = rd_en;
      m_rdd = rd_en ? model_read(int'(addr), lvl) : '0;
      if (wr_en && (int'(addr) % 8) == 0) m_mask[int'(addr) / 8] = wdata;
      void'(hist.pop_front());
      hist.push_back(src);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R4 irq vs model", {24'd0, irq}, {24'd0, m_irq});
      chk("R9 rd_valid vs model", {31'd0, rd_valid}, {31'd0, m_rdv});
      chk("R2 rd_data vs model", rd_data, m_rdd);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = 6'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    idle(3);
    chk("R1 irq in reset", {24'd0, irq}, '0);
    chk("R1 rd_valid in reset", {31'd0, rd_valid}, '0);
    rst_n = 1'b1;
    rd(2*8, d);
    chk("R1 mask zero after reset", d, '0);

    wr(3*8, 32'hA5A5_0F0F);
    rd(3*8, d);
    chk("R2 mask readback", d, 32'hA5A5_0F0F);
    rd(2*8, d);
    chk("R7 neighbour mask untouched", d, '0);

    // status write ignored, reserved offsets
    wr(3*8 + 4, 32'hFFFF_FFFF);
    rd(3*8, d);
    chk("R3 status write ignored", d, 32'hA5A5_0F0F);
    wr(3*8 + 2, 32'h1234_5678);
    rd(3*8, d);
    chk("R8 reserved write ignored", d, 32'hA5A5_0F0F);
    rd(3*8 + 6, d);
    chk("R8 reserved reads zero", d, '0);
    wr(3*8, '0);

    // R5 latency: enable bit 5 on channels 1 and 3
    wr(1*8, 32'h0000_0020);
    wr(3*8, 32'h0000_0020);
    idle(3);
    @(negedge clk); src = 32'h0000_0020;
    idle(2);
    chk("R5 irq not yet after two edges", {24'd0, irq}, '0);
    idle(1);
    chk("R5 R7 irq after third edge", {24'd0, irq}, 32'h0000_000A);
    rd(1*8 + 4, d);
    chk("R3 status shows pending", d, 32'h0000_0020);

    // R6 mask drop
    @(negedge clk); wr_en = 1'b1; addr = 6'(1*8); wdata = '0;
    @(negedge clk); wr_en = 1'b0;
    chk("R6 irq still high on write edge", {31'd0, irq[1]}, 32'd1);
    @(negedge clk);
    chk("R6 irq low one edge later", {31'd0, irq[1]}, '0);
    chk("R7 other channel stays high", {31'd0, irq[3]}, 32'd1);

    // R10 read and write same cycle
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 6'(3*8); wdata = 32'hFFFF_0000;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 read returns old mask", rd_data, 32'h0000_0020);
    chk("R9 rd_valid pulse", {31'd0, rd_valid}, 32'd1);
    @(negedge clk);
    chk("R9 rd_valid drops", {31'd0, rd_valid}, '0);

    // split grouping: ch0 low half, ch3 high half (already FFFF0000)
    wr(0, 32'h0000_FFFF);
    @(negedge clk); src = 32'h0010_0000;
    idle(3);
    chk("R4 high-half group on ch3 only", {24'd0, irq}, 32'h0000_0008);
    @(negedge clk); src = 32'h0000_0004;
    idle(3);
    chk("R4 low-half group on ch0 only", {24'd0, irq}, 32'h0000_0001);
    @(negedge clk); src = '0;
    idle(3);
    chk("R4 all low when sources drop", {24'd0, irq}, '0);

    // pattern sweep against model
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); src = 32'h1 << (i % 32) | 32'h8000_0000 >> (i % 7);
      if (i % 5 == 0) wr((i % 8) * 8, 32'hF0F0_F0F0 >> (i % 9));
    end
    idle(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule